// File: doc/BRIEF.md
# Fixed-point least-squares line fitter

The block fits a straight line y = a·x + b to a fixed set of eight training pairs held in signed fixed point. The pairs arrive one word at a time over a simple write port: an index selects the sample and a select bit chooses whether the word is its input value or its target value. The words are kept in a register bank, so the bank acts as the buffer for the whole set. A start strobe launches a fit and a done flag marks the moment the slope and intercept are valid.

When a fit is launched, the bank is read in parallel. All eight products x·x and x·y are formed at the same time and summed in one cycle, together with Σx and Σy. From these moments the block builds the numerators and the common denominator of the closed-form two-parameter normal equations. These are the slope term n·Σxy − Σx·Σy and the intercept term Σx²·Σy − Σx·Σxy, both over n·Σx² − (Σx)². The two quotients are then produced one after the other by one shared sequential restoring divider. Each result is rounded to nearest and clamped to the signed Q8.8 range.

If every x is equal, the denominator is zero. In that case the block raises an error flag, returns a slope of zero, and returns the rounded mean of y as the intercept.

Top module: `lsq_line_fit`

## Requirements
- R1: A cycle with load_we high writes load_data into sample load_idx (0 to 7). The word is stored as the input value when load_is_y is 0 and as the target value when load_is_y is 1. All values are signed two's-complement Q8.8 with 8 fraction bits.
- R2: A start pulse while busy is low launches a fit. In the next cycle busy is high and done is low. A start pulse while busy is high is ignored and does not restart the fit or change its timing.
- R3: For a non-degenerate set, slope equals the least-squares slope (8·Σxy − Σx·Σy)/(8·Σx² − (Σx)²) in Q8.8, within one LSB.
- R4: For a non-degenerate set, intercept equals (Σx²·Σy − Σx·Σxy)/(8·Σx² − (Σx)²) in Q8.8, within one LSB.
- R5: A result outside the Q8.8 range is clamped to 32767 (0x7FFF) when positive and to −32768 (0x8000) when negative.
- R6: When 8·Σx² − (Σx)² is zero, err is 1, slope is 0, and intercept is the mean of y within one LSB. A fit with a non-zero denominator leaves err at 0.
- R7: done rises the same fixed number of cycles after the accepted start for every fit, degenerate or not, and it rises only after a busy cycle.
- R8: done, slope, intercept and err stay stable until the next accepted start, and done falls when that start is accepted.
- R9: After reset, busy, done and err are 0, and slope and intercept are 0.
- R10: The samples are captured at the accepted start. A write during a running fit does not change that fit's results, but it does take effect for the next fit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_we | input | 1 | Write strobe for one sample word |
| load_is_y | input | 1 | 0 writes the input value, 1 writes the target value |
| load_idx | input | 3 | Sample index |
| load_data | input | 16 | Q8.8 sample word |
| start | input | 1 | Fit launch strobe |
| busy | output | 1 | High while a fit is running |
| done | output | 1 | High while slope and intercept are valid |
| err | output | 1 | Degenerate set (all x equal) |
| slope | output | 16 | Fitted slope, Q8.8 |
| intercept | output | 16 | Fitted intercept, Q8.8 |

## Verification
The assertions assume that start is a clean synchronous strobe and that the outputs are judged only between one done and the next accepted start. The stimulus drives start and all load signals at the falling edge, for whole cycles. It deliberately pulses start and writes a sample while a fit is running, so that the ignored-start and captured-sample rules are exercised rather than merely assumed. The expected results come from real-valued arithmetic on the same samples and are compared within one LSB. Test sets include exact lines, pseudo-random data across the full input range, slopes steep enough to clamp, and a set where every x is the same.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SUM,
      ST_PREP_S,
      ST_DIV_S,
      ST_PREP_I,
      ST_DIV_I,
      ST_OUT
   } fit_state_e;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lsq_sample_bank.sv
module lsq_sample_bank #(
   parameter int N_SAMP = 8,
   parameter int DATA_W = 16,
   parameter int IDX_W  = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic                           wr_is_y,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [N_SAMP-1:0][DATA_W-1:0]  xs,
   output logic [N_SAMP-1:0][DATA_W-1:0]  ys
);

   for (genvar i = 0; i < N_SAMP; i++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            xs[i] <= '0;
            ys[i] <= '0;
         end else if (hit) begin
            if (wr_is_y) ys[i] <= wr_data;
            else         xs[i] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/lsq_moment_sum.sv
module lsq_moment_sum #(
   parameter int N_SAMP = 8,
   parameter int DATA_W = 16,
   parameter int SX_W   = 19,
   parameter int SXX_W  = 35
) (
   input  logic [N_SAMP-1:0][DATA_W-1:0] xs,
   input  logic [N_SAMP-1:0][DATA_W-1:0] ys,
   output logic signed [SX_W-1:0]        sum_x,
   output logic signed [SX_W-1:0]        sum_y,
   output logic signed [SXX_W-1:0]       sum_xx,
   output logic signed [SXX_W-1:0]       sum_xy
);

   localparam int P_W = 2 * DATA_W;

   logic signed [P_W-1:0] p_xx [N_SAMP];
   logic signed [P_W-1:0] p_xy [N_SAMP];

   for (genvar i = 0; i < N_SAMP; i++) begin : g_mul
      assign p_xx[i] = $signed(xs[i]) * $signed(xs[i]);
      assign p_xy[i] = $signed(xs[i]) * $signed(ys[i]);
   end

   always_comb begin
      sum_x  = '0;
      sum_y  = '0;
      sum_xx = '0;
      sum_xy = '0;
      for (int i = 0; i < N_SAMP; i++) begin
         sum_x  = sum_x  + {{(SX_W-DATA_W){xs[i][DATA_W-1]}}, xs[i]};
         sum_y  = sum_y  + {{(SX_W-DATA_W){ys[i][DATA_W-1]}}, ys[i]};
         sum_xx = sum_xx + {{(SXX_W-P_W){p_xx[i][P_W-1]}}, p_xx[i]};
         sum_xy = sum_xy + {{(SXX_W-P_W){p_xy[i][P_W-1]}}, p_xy[i]};
      end
   end

endmodule

// File: rtl/lsq_seq_div.sv
module lsq_seq_div #(
   parameter int DVD_W = 56,
   parameter int DVS_W = 39
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [DVD_W-1:0] dividend,
   input  logic [DVS_W-1:0] divisor,
   output logic             fin,
   output logic [DVD_W-1:0] quot
);

   localparam int CW = $clog2(DVD_W + 1);

   logic [DVS_W-1:0] rem;
   logic [DVD_W-1:0] work;
   logic [DVS_W-1:0] dvs;
   logic [CW-1:0]    cnt;

   logic [DVS_W:0]   shifted;
   logic [DVS_W:0]   trial;
   logic             take;

   assign shifted = {rem, work[DVD_W-1]};
   assign trial   = shifted - {1'b0, dvs};
   assign take    = !trial[DVS_W];
   assign quot    = work;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem  <= '0;
         work <= '0;
         dvs  <= '0;
         cnt  <= '0;
         fin  <= 1'b0;
      end else if (go) begin
         rem  <= '0;
         work <= dividend;
         dvs  <= divisor;
         cnt  <= CW'(DVD_W);
         fin  <= 1'b0;
      end else if (cnt != '0) begin
         rem  <= take ? trial[DVS_W-1:0] : shifted[DVS_W-1:0];
         work <= {work[DVD_W-2:0], take};
         cnt  <= cnt - 1'b1;
         fin  <= (cnt == CW'(1));
      end else begin
         fin  <= 1'b0;
      end
   end

endmodule

// File: rtl/lsq_round_sat.sv
module lsq_round_sat #(
   parameter int QW     = 56,
   parameter int DATA_W = 16
) (
   input  logic              neg,
   input  logic [QW-1:0]     q2,
   output logic [DATA_W-1:0] res
);

   localparam logic [QW-1:0] LIM_P = {{(QW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic [QW-1:0] LIM_N = LIM_P + 1'b1;

   logic [QW-1:0] half;

   always_comb begin
      half = (q2 >> 1) + {{(QW-1){1'b0}}, q2[0]};
      if (!neg) begin
         res = (half > LIM_P) ? {1'b0, {(DATA_W-1){1'b1}}} : half[DATA_W-1:0];
      end else begin
         res = (half > LIM_N) ? {1'b1, {(DATA_W-1){1'b0}}} : (~half[DATA_W-1:0] + 1'b1);
      end
   end

endmodule

// File: rtl/lsq_line_fit.sv
module lsq_line_fit
   import lsq_pkg::*;
#(
   parameter int N_SAMP = 8,
   parameter int DATA_W = 16,
   parameter int FRAC_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_we,
   input  logic                        load_is_y,
   input  logic [$clog2(N_SAMP)-1:0]   load_idx,
   input  logic [DATA_W-1:0]           load_data,
   input  logic                        start,
   output logic                        busy,
   output logic                        done,
   output logic                        err,
   output logic [DATA_W-1:0]           slope,
   output logic [DATA_W-1:0]           intercept
);

   localparam int LOG_N  = $clog2(N_SAMP);
   localparam int SX_W   = DATA_W + LOG_N;
   localparam int SXX_W  = 2 * DATA_W + LOG_N;
   localparam int NUM1_W = SXX_W + LOG_N + 1;
   localparam int NUM2_W = SXX_W + SX_W + 1;
   localparam int DEN_W  = NUM1_W;
   localparam int DVD_W  = max_i(NUM1_W + FRAC_W + 1, NUM2_W + 1);

   if ((1 << LOG_N) != N_SAMP || N_SAMP < 2) begin : g_bad_n
      $error("N_SAMP must be a power of two of at least 2");
   end
   if (FRAC_W >= DATA_W || DATA_W < 4) begin : g_bad_w
      $error("FRAC_W must be below DATA_W and DATA_W at least 4");
   end

   fit_state_e state;

   logic [N_SAMP-1:0][DATA_W-1:0] xs, ys;
   logic signed [SX_W-1:0]  c_sx, c_sy;
   logic signed [SXX_W-1:0] c_sxx, c_sxy;

   logic signed [SX_W-1:0]  sx, sy;
   logic signed [SXX_W-1:0] sxx, sxy;

   logic signed [NUM1_W-1:0] num1, den;
   logic signed [NUM2_W-1:0] num2;

   logic [DVD_W-1:0] q_slope;
   logic             div_go, div_fin;
   logic [DVD_W-1:0] div_dvd, div_quot;

   lsq_sample_bank #(.N_SAMP(N_SAMP), .DATA_W(DATA_W), .IDX_W(LOG_N)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (load_we),
      .wr_is_y (load_is_y),
      .wr_idx  (load_idx),
      .wr_data (load_data),
      .xs      (xs),
      .ys      (ys)
   );

   lsq_moment_sum #(.N_SAMP(N_SAMP), .DATA_W(DATA_W), .SX_W(SX_W), .SXX_W(SXX_W)) u_mom (
      .xs     (xs),
      .ys     (ys),
      .sum_x  (c_sx),
      .sum_y  (c_sy),
      .sum_xx (c_sxx),
      .sum_xy (c_sxy)
   );

   // normal-equation terms from the captured moments
   logic signed [2*SX_W-1:0]       p_sxsy, p_sxsx;
   logic signed [SXX_W+SX_W-1:0]   p_sxxsy, p_sxsxy;
   logic signed [NUM1_W-1:0]       n_sxy, n_sxx, c_num1, c_den;
   logic signed [NUM2_W-1:0]       c_num2;

   assign p_sxsy  = sx * sy;
   assign p_sxsx  = sx * sx;
   assign p_sxxsy = sxx * sy;
   assign p_sxsxy = sx * sxy;
   assign n_sxy   = {{(NUM1_W-SXX_W){sxy[SXX_W-1]}}, sxy} << LOG_N;
   assign n_sxx   = {{(NUM1_W-SXX_W){sxx[SXX_W-1]}}, sxx} << LOG_N;
   assign c_num1  = n_sxy - {{(NUM1_W-2*SX_W){p_sxsy[2*SX_W-1]}}, p_sxsy};
   assign c_den   = n_sxx - {{(NUM1_W-2*SX_W){p_sxsx[2*SX_W-1]}}, p_sxsx};
   assign c_num2  = {p_sxxsy[SXX_W+SX_W-1], p_sxxsy} - {p_sxsxy[SXX_W+SX_W-1], p_sxsxy};

   // unsigned magnitudes fed to the divider
   logic [NUM1_W-1:0] mag1;
   logic [NUM2_W-1:0] mag2;
   logic [DVD_W-1:0]  dvd_slope, dvd_int;

   assign mag1      = num1[NUM1_W-1] ? NUM1_W'(-num1) : NUM1_W'(num1);
   assign mag2      = num2[NUM2_W-1] ? NUM2_W'(-num2) : NUM2_W'(num2);
   assign dvd_slope = DVD_W'({mag1, {(FRAC_W+1){1'b0}}});
   assign dvd_int   = DVD_W'({mag2, 1'b0});
   assign div_dvd   = (state == ST_PREP_I) ? dvd_int : dvd_slope;
   assign div_go    = (state == ST_PREP_S) || (state == ST_PREP_I);

   lsq_seq_div #(.DVD_W(DVD_W), .DVS_W(DEN_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (div_go),
      .dividend (div_dvd),
      .divisor  (DEN_W'(den)),
      .fin      (div_fin),
      .quot     (div_quot)
   );

   logic [DATA_W-1:0] r_slope, r_int;

   lsq_round_sat #(.QW(DVD_W), .DATA_W(DATA_W)) u_rs_slope (
      .neg (num1[NUM1_W-1]),
      .q2  (q_slope),
      .res (r_slope)
   );

   lsq_round_sat #(.QW(DVD_W), .DATA_W(DATA_W)) u_rs_int (
      .neg (num2[NUM2_W-1]),
      .q2  (div_quot),
      .res (r_int)
   );

   // mean of y for the degenerate case, rounded half up
   logic signed [SX_W:0] mean_t, mean_s;
   logic                 degen;

   assign mean_t = {sy[SX_W-1], sy} + (SX_W+1)'(N_SAMP / 2);
   assign mean_s = mean_t >>> LOG_N;
   assign degen  = (den == '0);
   assign busy   = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         sx        <= '0;
         sy        <= '0;
         sxx       <= '0;
         sxy       <= '0;
         num1      <= '0;
         num2      <= '0;
         den       <= '0;
         q_slope   <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
         slope     <= '0;
         intercept <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  sx    <= c_sx;
                  sy    <= c_sy;
                  sxx   <= c_sxx;
                  sxy   <= c_sxy;
                  done  <= 1'b0;
                  state <= ST_SUM;
               end
            end
            ST_SUM: begin
               num1  <= c_num1;
               num2  <= c_num2;
               den   <= c_den;
               state <= ST_PREP_S;
            end
            ST_PREP_S: state <= ST_DIV_S;
            ST_DIV_S: begin
               if (div_fin) begin
                  q_slope <= div_quot;
                  state   <= ST_PREP_I;
               end
            end
            ST_PREP_I: state <= ST_DIV_I;
            ST_DIV_I: begin
               if (div_fin) state <= ST_OUT;
            end
            ST_OUT: begin
               err       <= degen;
               slope     <= degen ? '0 : r_slope;
               intercept <= degen ? mean_s[DATA_W-1:0] : r_int;
               done      <= 1'b1;
               state     <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lsq_line_fit_chk.sv
module lsq_line_fit_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [DATA_W-1:0] slope,
   input logic [DATA_W-1:0] intercept
);

   p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   p_start_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done));

   p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   p_hold_results_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(slope) && $stable(intercept) && $stable(err)));

   p_err_zero_slope_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (slope == '0));

endmodule

bind lsq_line_fit lsq_line_fit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .slope     (slope),
   .intercept (intercept)
);

// File: tb/lsq_line_fit_tb.sv
`timescale 1ns/1ps
module lsq_line_fit_tb;

   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_we = 1'b0;
   logic        load_is_y = 1'b0;
   logic [2:0]  load_idx = '0;
   logic [15:0] load_data = '0;
   logic        start = 1'b0;
   logic        busy, done, err;
   logic [15:0] slope, intercept;

   always #2.5 clk = ~clk;

   lsq_line_fit u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_we   (load_we),
      .load_is_y (load_is_y),
      .load_idx  (load_idx),
      .load_data (load_data),
      .start     (start),
      .busy      (busy),
      .done      (done),
      .err       (err),
      .slope     (slope),
      .intercept (intercept)
   );

   typedef struct {
      int s;
      int b;
      bit e;
   } exp_t;

   exp_t  q_exp [$];
   string q_tag [$];

   int n_chk = 0;
   int n_bad = 0;
   int ref_lat = -1;
   bit finished = 0;

   logic signed [15:0] xv [N];
   logic signed [15:0] yv [N];
   int unsigned seed = 32'h1234_5678;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int to_q(input real v);
      real s;
      s = v * 256.0;
      if (s > 32767.0)  s = 32767.0;
      if (s < -32768.0) s = -32768.0;
      return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
   endfunction

   function automatic int sx16(input logic [15:0] v);
      return int'($signed(v));
   endfunction

   // driver side: reference from the requirements, pushed into the scoreboard
   task automatic push_expect(input string tag);
      longint sx = 0, sy = 0, sxx = 0, sxy = 0, den;
      exp_t   e;
      for (int i = 0; i < N; i++) begin
         sx  += longint'(xv[i]);
         sy  += longint'(yv[i]);
         sxx += longint'(xv[i]) * longint'(xv[i]);
         sxy += longint'(xv[i]) * longint'(yv[i]);
      end
      den = 8 * sxx - sx * sx;
      if (den == 0) begin
         e.e = 1'b1;
         e.s = 0;
         e.b = to_q(real'(sy) / 8.0 / 256.0);
      end else begin
         e.e = 1'b0;
         e.s = to_q(real'(8 * sxy - sx * sy) / real'(den));
         e.b = to_q((real'(sxx) * real'(sy) - real'(sx) * real'(sxy)) / real'(den) / 256.0);
      end
      q_exp.push_back(e);
      q_tag.push_back(tag);
   endtask

   task automatic load_all;
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         load_we = 1'b1; load_is_y = 1'b0; load_idx = 3'(i); load_data = xv[i];
         @(negedge clk);
         load_is_y = 1'b1; load_data = yv[i];
      end
      @(negedge clk);
      load_we = 1'b0;
   endtask

   task automatic run_fit(input string tag, input bit poke_start, input bit poke_load);
      int lat;
      push_expect(tag);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1 && done === 1'b0, "R2", "busy/done after start",
          int'({busy, done}), 2);
      lat = 1;
      while (done !== 1'b1 && lat < 5000) begin
         start   = poke_start && (lat == 20);
         load_we = poke_load && (lat == 10);
         if (poke_load && lat == 10) begin
            load_is_y = 1'b0; load_idx = 3'd0; load_data = 16'h7F00;
         end
         @(negedge clk);
         lat++;
      end
      start   = 1'b0;
      load_we = 1'b0;
      if (ref_lat < 0) ref_lat = lat;
      chk(lat == ref_lat, "R7", "latency", lat, ref_lat);
      @(negedge clk);
   endtask

   task automatic rnd_set;
      for (int i = 0; i < N; i++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         xv[i] = seed[31:16];
         seed = seed * 32'd1103515245 + 32'd12345;
         yv[i] = seed[31:16];
      end
   endtask

   // monitor side: pops the scoreboard on each rising done
   bit done_q = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (done === 1'b1 && !done_q) begin
            if (q_exp.size() == 0) begin
               chk(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
               exp_t  e;
               string t;
               int    ds, db;
               e = q_exp.pop_front();
               t = q_tag.pop_front();
               ds = sx16(slope) - e.s;
               db = sx16(intercept) - e.b;
               chk(ds <= 1 && ds >= -1, t, "slope", sx16(slope), e.s);
               chk(db <= 1 && db >= -1, t, "intercept", sx16(intercept), e.b);
               chk(err === e.e, t, "err", int'(err), int'(e.e));
            end
         end
         done_q = (done === 1'b1);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] s_hold, b_hold;
      repeat (4) @(negedge clk);
      // R9 reset state
      chk(busy === 1'b0, "R9", "busy", int'(busy), 0);
      chk(done === 1'b0, "R9", "done", int'(done), 0);
      chk(err === 1'b0, "R9", "err", int'(err), 0);
      chk(slope === 16'h0, "R9", "slope", sx16(slope), 0);
      chk(intercept === 16'h0, "R9", "intercept", sx16(intercept), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R3 R4: exact line y = 2x + 1
      for (int i = 0; i < N; i++) begin
         xv[i] = 16'(256 * i);
         yv[i] = 16'(512 * i + 256);
      end
      load_all();
      run_fit("R3", 0, 0);

      // R8: results held until the next start
      s_hold = slope; b_hold = intercept;
      repeat (6) @(negedge clk);
      chk(done === 1'b1, "R8", "done held", int'(done), 1);
      chk(slope === s_hold && intercept === b_hold, "R8", "slope held",
          sx16(slope), sx16(s_hold));

      // R4: y = -0.5x + 3 with negative x
      for (int i = 0; i < N; i++) begin
         xv[i] = 16'(256 * i - 896);
         yv[i] = 16'(768 - (256 * i - 896) / 2);
      end
      load_all();
      run_fit("R4", 0, 0);

      // R3 R4 R5: pseudo-random full-range sets
      for (int k = 0; k < 4; k++) begin
         rnd_set();
         load_all();
         run_fit("R3", 0, 0);
      end

      // R5: positive and negative clamping
      for (int i = 0; i < N; i++) begin
         xv[i] = 16'(i % 2);
         yv[i] = 16'((i % 2) * 25600);
      end
      load_all();
      run_fit("R5", 0, 0);
      for (int i = 0; i < N; i++) yv[i] = 16'(-(i % 2) * 25600);
      load_all();
      run_fit("R5", 0, 0);

      // R6: all x equal
      for (int i = 0; i < N; i++) begin
         xv[i] = 16'(768);
         yv[i] = 16'(100 * i - 301);
      end
      load_all();
      run_fit("R6", 0, 0);

      // R6: err clears on a regular fit; R2: start during busy ignored
      for (int i = 0; i < N; i++) begin
         xv[i] = 16'(256 * i);
         yv[i] = 16'(512 * i + 256);
      end
      load_all();
      run_fit("R6", 1, 0);

      // R10: a write during a fit affects only the following fit
      run_fit("R10", 0, 1);
      xv[0] = 16'h7F00;
      run_fit("R10", 0, 0);

      repeat (4) @(negedge clk);
      chk(q_exp.size() == 0, "R8", "pending results", q_exp.size(), 0);
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule